// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block receives a stereo serial audio stream whose bit clock and frame clock come from outside. It runs on a faster system clock and passes the three incoming lines through synchronizers. It then finds the bit-clock rising edges and the frame-clock edges, and counts bits from each frame reference. From these it rebuilds one left word and one right word per frame. Four framings are supported: left-justified, I2S, and two DSP variants. The DSP variants differ only in whether the first data bit follows the frame pulse at once or one bit later.

The active word length is set at run time. Captured words are placed MSB-first in a fixed-width output word, and the unused low bits are zero. Each completed left/right pair is presented together with a one-cycle strobe. In the DSP framings the frame pulse may have any width. A pulse that goes low too close to the next frame start raises a one-cycle error flag.

Top module: `aud_serial_rx`

## Requirements
- R1: While reset is high, and after it is released, `left_out` and `right_out` read zero and `pair_valid` and `frame_err` are low until the first complete pair arrives.
- R2: With `fmt_sel` = 0 (left-justified), every frame-clock transition is a reference point. The MSB is taken on the first bit-clock rising edge after it. Frame clock high carries the left word and low carries the right word.
- R3: With `fmt_sel` = 1 (I2S), every frame-clock transition is a reference point. The MSB is taken on the second bit-clock rising edge after it. Frame clock low carries the left word and high carries the right word.
- R4: With `fmt_sel` = 3, the left MSB is taken on the first bit-clock rising edge after a frame-clock rising edge. With `fmt_sel` = 2, it is taken on the second. In both, the right MSB is taken on the bit-clock edge right after the left LSB.
- R5: In the DSP framings (2 and 3) the frame pulse may be any width shorter than a frame. Only its rising edge starts a frame, and its falling edge does not disturb the bit count.
- R6: In the DSP framings, `frame_err` pulses for one clock when a frame-clock rising edge arrives after fewer than two bit-clock rising edges since the last frame-clock falling edge. It never pulses in framings 0 and 1.
- R7: The word length is `wl_m1`+1 bits. Each word is placed with its MSB at bit 31 of the output, and the low 31-`wl_m1` bits read zero.
- R8: Data on bit-clock edges after a channel's LSB and before the next reference point has no effect on the output words.
- R9: `pair_valid` is high for exactly one clock after the right LSB is captured. It presents that frame's left and right words together, and the outputs hold their values between strobes.
- R10: The bit clock, frame clock and data are each synchronized through two flip-flops, and the system clock must run at four or more times the bit clock. Bits that arrive after reset but before the first reference point produce no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 2 | Framing: 0 left-justified, 1 I2S, 2 DSP one-bit delay, 3 DSP no delay |
| wl_m1 | input | 5 | Word length minus one |
| bclk_in | input | 1 | External bit clock |
| lrclk_in | input | 1 | External frame clock or frame pulse |
| sdata_in | input | 1 | Serial data |
| left_out | output | 32 | Left word, MSB-aligned |
| right_out | output | 32 | Right word, MSB-aligned |
| pair_valid | output | 1 | One-cycle strobe when a new pair is presented |
| frame_err | output | 1 | One-cycle flag for a frame pulse that fell too late |

## Verification
The bench builds the block with a 32-bit output word and a two-stage synchronizer. The bit clock runs at one eighth of the system clock, so every bit-clock half lasts four system clocks. It drives word lengths of 8, 16, 20, 24 and 32 bits. This covers both halves exactly full of data and halves padded with junk bits. It also covers DSP frames whose pulse is one bit wide, a few bits wide, nearly a whole frame wide, and one bit short of overlapping the next frame.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

    typedef enum logic [1:0] {
        FMT_LJ    = 2'd0,
        FMT_I2S   = 2'd1,
        FMT_DSP_A = 2'd2,
        FMT_DSP_B = 2'd3
    } fmt_e;

    // Raw serial lines as sampled in the system clock domain.
    typedef struct packed {
        logic bclk;
        logic lrclk;
        logic sdata;
    } pins_t;

    // Frame-pulse framings start frames on the rising edge only.
    function automatic logic is_dsp(fmt_e f);
        return (f == FMT_DSP_A) || (f == FMT_DSP_B);
    endfunction

    // One bit of delay between reference and MSB.
    function automatic logic msb_delay(fmt_e f);
        return (f == FMT_I2S) || (f == FMT_DSP_A);
    endfunction

    // Channel carried by a frame-clock level in the two-half framings.
    function automatic logic level_is_right(fmt_e f, logic lr);
        return (f == FMT_LJ) ? ~lr : lr;
    endfunction

endpackage

// File: rtl/aud_rx_edge.sv
module aud_rx_edge
    import aud_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  pins_t pins_in,
    output pins_t pins_lvl,
    output logic  bclk_rise,
    output logic  lr_rise,
    output logic  lr_fall
);
    localparam int SETTLE = SYNC_STAGES + 1;
    localparam int SET_W  = $clog2(SETTLE + 1);

    pins_t [SYNC_STAGES-1:0] stage_q;
    pins_t                   prev_q;
    logic  [SET_W-1:0]       settle_q;
    logic                    ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q  <= '0;
            prev_q   <= '0;
            settle_q <= '0;
        end else begin
            stage_q <= {stage_q[SYNC_STAGES-2:0], pins_in};
            prev_q  <= stage_q[SYNC_STAGES-1];
            if (settle_q != SET_W'(SETTLE))
                settle_q <= settle_q + 1'b1;
        end
    end

    // Edges are masked until the chain holds real pin values.
    always_comb begin
        ready     = (settle_q == SET_W'(SETTLE));
        pins_lvl  = stage_q[SYNC_STAGES-1];
        bclk_rise = ready &  pins_lvl.bclk  & ~prev_q.bclk;
        lr_rise   = ready &  pins_lvl.lrclk & ~prev_q.lrclk;
        lr_fall   = ready & ~pins_lvl.lrclk &  prev_q.lrclk;
    end

    // R10
    bclk_rise_gap_chk: assert property (@(posedge clk) disable iff (rst)
        bclk_rise |=> !bclk_rise);

endmodule

// File: rtl/aud_rx_framer.sv
module aud_rx_framer
    import aud_rx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  fmt_e              fmt,
    input  logic [$clog2(DATA_W)-1:0] wl_m1,
    input  logic              bclk_rise,
    input  logic              lr_rise,
    input  logic              lr_fall,
    input  logic              lr_lvl,
    input  logic              sdata,
    output logic              bit_vld,
    output logic              bit_right,
    output logic [$clog2(DATA_W)-1:0] bit_idx,
    output logic              bit_last,
    output logic              bit_dat,
    output logic              frame_err
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int CNT_W = $clog2(2 * DATA_W + 2) + 1;
    localparam logic [CNT_W-1:0] POS_MAX = '1;

    logic [CNT_W-1:0] pos_q;
    logic             armed_q;
    logic             right_q;
    logic [1:0]       gap_q;
    logic             err_q;

    logic             dsp, off, ref_evt, cur_armed, cur_right, early, in_rng;
    logic [CNT_W-1:0] cur_pos, slot, rslot, wl_ext;

    always_comb begin
        dsp       = is_dsp(fmt);
        off       = msb_delay(fmt);
        ref_evt   = dsp ? lr_rise : (lr_rise | lr_fall);
        cur_pos   = ref_evt ? '0 : pos_q;
        cur_armed = armed_q | ref_evt;
        cur_right = ref_evt ? (!dsp && level_is_right(fmt, lr_lvl)) : right_q;
        wl_ext    = CNT_W'(wl_m1);
        early     = cur_pos < CNT_W'(off);
        slot      = cur_pos - CNT_W'(off);
        rslot     = slot - wl_ext - CNT_W'(1);
        in_rng    = 1'b0;
        bit_right = cur_right;
        bit_idx   = slot[IDX_W-1:0];
        if (!early) begin
            if (!dsp) begin
                in_rng = (slot <= wl_ext);
            end else if (slot <= wl_ext) begin
                in_rng    = 1'b1;
                bit_right = 1'b0;
            end else if (rslot <= wl_ext) begin
                in_rng    = 1'b1;
                bit_right = 1'b1;
                bit_idx   = rslot[IDX_W-1:0];
            end
        end
        bit_vld   = bclk_rise & cur_armed & in_rng;
        bit_last  = (bit_idx == wl_m1);
        bit_dat   = sdata;
        frame_err = err_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q   <= POS_MAX;
            armed_q <= 1'b0;
            right_q <= 1'b0;
            gap_q   <= 2'd2;
            err_q   <= 1'b0;
        end else begin
            pos_q   <= (bclk_rise && cur_pos != POS_MAX) ? cur_pos + 1'b1 : cur_pos;
            armed_q <= cur_armed;
            right_q <= cur_right;
            if (lr_fall)
                gap_q <= 2'd0;
            else if (bclk_rise && gap_q != 2'd2)
                gap_q <= gap_q + 1'b1;
            err_q <= dsp && lr_rise && (gap_q != 2'd2);
        end
    end

    // R6
    err_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> !frame_err);

    // R6
    err_dsp_only_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> $past(is_dsp(fmt)));

endmodule

// File: rtl/aud_rx_assemble.sv
module aud_rx_assemble #(
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bit_vld,
    input  logic                      bit_right,
    input  logic [$clog2(DATA_W)-1:0] bit_idx,
    input  logic                      bit_last,
    input  logic                      bit_dat,
    output logic [DATA_W-1:0]         left_out,
    output logic [DATA_W-1:0]         right_out,
    output logic                      pair_valid
);
    localparam logic [DATA_W-1:0] TOP_BIT = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] work_l_q, work_r_q, base, merged;
    logic              valid_q;

    // A word restarts at its MSB; later bits fill in below it.
    always_comb begin
        base       = bit_right ? work_r_q : work_l_q;
        if (bit_idx == '0)
            base = '0;
        merged     = base | (bit_dat ? (TOP_BIT >> bit_idx) : '0);
        pair_valid = valid_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            work_l_q  <= '0;
            work_r_q  <= '0;
            left_out  <= '0;
            right_out <= '0;
            valid_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (bit_vld) begin
                if (bit_right) begin
                    work_r_q <= merged;
                    if (bit_last) begin
                        right_out <= merged;
                        left_out  <= work_l_q;
                        valid_q   <= 1'b1;
                    end
                end else begin
                    work_l_q <= merged;
                end
            end
        end
    end

    // R9
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        pair_valid |=> !pair_valid);

    // R9
    left_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (left_out != $past(left_out)) |-> pair_valid);

    // R9
    right_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (right_out != $past(right_out)) |-> pair_valid);

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
    import aud_rx_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [1:0]                fmt_sel,
    input  logic [$clog2(DATA_W)-1:0] wl_m1,
    input  logic                      bclk_in,
    input  logic                      lrclk_in,
    input  logic                      sdata_in,
    output logic [DATA_W-1:0]         left_out,
    output logic [DATA_W-1:0]         right_out,
    output logic                      pair_valid,
    output logic                      frame_err
);
    localparam int IDX_W = $clog2(DATA_W);

    pins_t             pins_raw, pins_lvl;
    logic              bclk_rise, lr_rise, lr_fall;
    logic              bit_vld, bit_right, bit_last, bit_dat;
    logic [IDX_W-1:0]  bit_idx;

    assign pins_raw = '{bclk: bclk_in, lrclk: lrclk_in, sdata: sdata_in};

    aud_rx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst       (rst),
        .pins_in   (pins_raw),
        .pins_lvl  (pins_lvl),
        .bclk_rise (bclk_rise),
        .lr_rise   (lr_rise),
        .lr_fall   (lr_fall)
    );

    aud_rx_framer #(.DATA_W(DATA_W)) u_framer (
        .clk       (clk),
        .rst       (rst),
        .fmt       (fmt_e'(fmt_sel)),
        .wl_m1     (wl_m1),
        .bclk_rise (bclk_rise),
        .lr_rise   (lr_rise),
        .lr_fall   (lr_fall),
        .lr_lvl    (pins_lvl.lrclk),
        .sdata     (pins_lvl.sdata),
        .bit_vld   (bit_vld),
        .bit_right (bit_right),
        .bit_idx   (bit_idx),
        .bit_last  (bit_last),
        .bit_dat   (bit_dat),
        .frame_err (frame_err)
    );

    aud_rx_assemble #(.DATA_W(DATA_W)) u_asm (
        .clk        (clk),
        .rst        (rst),
        .bit_vld    (bit_vld),
        .bit_right  (bit_right),
        .bit_idx    (bit_idx),
        .bit_last   (bit_last),
        .bit_dat    (bit_dat),
        .left_out   (left_out),
        .right_out  (right_out),
        .pair_valid (pair_valid)
    );

endmodule

// File: tb/tb_aud_serial_rx.sv
module tb_aud_serial_rx;
    localparam int DW   = 32;
    localparam int HALF = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    fmt_sel = 2'd0;
    logic [4:0]    wl_m1 = 5'd31;
    logic          bclk_in = 1'b0, lrclk_in = 1'b0, sdata_in = 1'b0;
    logic [DW-1:0] left_out, right_out;
    logic          pair_valid, frame_err;

    aud_serial_rx dut (
        .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .wl_m1(wl_m1),
        .bclk_in(bclk_in), .lrclk_in(lrclk_in), .sdata_in(sdata_in),
        .left_out(left_out), .right_out(right_out),
        .pair_valid(pair_valid), .frame_err(frame_err)
    );

    always #10 clk = ~clk;

    int            n_tests = 0, n_fail = 0, err_seen = 0;
    bit            done = 1'b0, monitor_on = 1'b0;
    logic [63:0]   exp_q[$];
    string         tag_q[$];
    logic [DW-1:0] prev_l = '0, prev_r = '0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference model: queue of expected pairs, compared on every clock.
    always @(negedge clk) begin
        if (monitor_on && !rst) begin
            if (pair_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9/R10 unexpected pair", {left_out, right_out}, 64'h0);
                end else begin
                    logic [63:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({left_out, right_out} == e, t, {left_out, right_out}, e);
                end
            end else begin
                // R9 outputs held between strobes
                check(left_out == prev_l && right_out == prev_r, "R9 hold",
                      {left_out, right_out}, {prev_l, prev_r});
            end
            if (frame_err) err_seen++;
            prev_l = left_out;
            prev_r = right_out;
        end
    end

    function automatic logic [DW-1:0] msk(input logic [DW-1:0] v, input int wl);
        return v & ({DW{1'b1}} << (DW - wl));
    endfunction

    task automatic slot(input logic lr, input logic d);
        @(negedge clk);
        bclk_in  = 1'b0;
        lrclk_in = lr;
        sdata_in = d;
        repeat (HALF - 1) @(negedge clk);
        @(negedge clk);
        bclk_in = 1'b1;
        repeat (HALF - 1) @(negedge clk);
    endtask

    task automatic start(input int fmt, input int wl, input logic idle_lr);
        rst = 1'b1;
        monitor_on = 1'b0;
        fmt_sel = 2'(fmt);
        wl_m1 = 5'(wl - 1);
        bclk_in = 1'b0;
        lrclk_in = idle_lr;
        sdata_in = 1'b0;
        repeat (5) @(negedge clk);
        // R1 reset state
        check(left_out == '0 && right_out == '0 && !pair_valid && !frame_err,
              "R1 reset", {left_out, right_out}, 64'h0);
        rst = 1'b0;
        err_seen = 0;
        prev_l = '0;
        prev_r = '0;
        monitor_on = 1'b1;
        // R10 junk before any reference point must be dropped
        repeat (6) slot(idle_lr, 1'($urandom));
    endtask

    task automatic finish_case(input int exp_err, input string tag);
        repeat (30) @(negedge clk);
        check(exp_q.size() == 0, {tag, " pairs delivered"}, 64'(exp_q.size()), 64'h0);
        // R6 error count for the scenario
        check(err_seen == exp_err, "R6 error count", 64'(err_seen), 64'(exp_err));
        exp_q.delete();
        tag_q.delete();
    endtask

    // Two-half framings (R2, R3); slots per half >= wl + delay.
    task automatic send_half(input int fmt, input int wl, input int slots, input string tag);
        logic [DW-1:0] l, r;
        logic left_lvl;
        int off;
        l = $urandom;
        r = $urandom;
        left_lvl = (fmt == 0);
        off = (fmt == 1) ? 1 : 0;
        exp_q.push_back({msk(l, wl), msk(r, wl)});
        tag_q.push_back(tag);
        for (int s = 0; s < slots; s++) begin
            int k = s - off;
            slot(left_lvl, (k >= 0 && k < wl) ? l[DW-1-k] : 1'($urandom));
        end
        for (int s = 0; s < slots; s++) begin
            int k = s - off;
            slot(~left_lvl, (k >= 0 && k < wl) ? r[DW-1-k] : 1'($urandom));
        end
    endtask

    // Frame-pulse framings (R4, R5).
    task automatic send_dsp(input int fmt, input int wl, input int slots, input int pw, input string tag);
        logic [DW-1:0] l, r;
        int off;
        l = $urandom;
        r = $urandom;
        off = (fmt == 2) ? 1 : 0;
        exp_q.push_back({msk(l, wl), msk(r, wl)});
        tag_q.push_back(tag);
        for (int s = 0; s < slots; s++) begin
            int k = s - off;
            logic d;
            if (k >= 0 && k < wl)           d = l[DW-1-k];
            else if (k >= wl && k < 2 * wl) d = r[DW-1-(k-wl)];
            else                            d = 1'($urandom);
            slot(s < pw, d);
        end
    endtask

    initial begin
        // R2 left-justified, padded halves, R7 and R8 junk ignored
        start(0, 24, 1'b0);
        repeat (3) send_half(0, 24, 32, "R2/R7/R8 LJ wl24");
        finish_case(0, "R2");
        // R2 left-justified, full 32-bit halves
        start(0, 32, 1'b0);
        repeat (2) send_half(0, 32, 32, "R2/R7 LJ wl32");
        finish_case(0, "R2");
        // R3 I2S
        start(1, 16, 1'b1);
        repeat (3) send_half(1, 16, 20, "R3/R8 I2S wl16");
        finish_case(0, "R3");
        start(1, 32, 1'b1);
        repeat (2) send_half(1, 32, 33, "R3/R7 I2S wl32");
        finish_case(0, "R3");
        // R4 mode with no delay, R5 varied pulse widths
        start(3, 16, 1'b0);
        send_dsp(3, 16, 40, 1, "R4/R5 DSP-B pw1");
        send_dsp(3, 16, 40, 7, "R4/R5 DSP-B pw7");
        send_dsp(3, 16, 40, 30, "R4/R5 DSP-B pw30");
        finish_case(0, "R4");
        // R4 mode with one-bit delay
        start(2, 20, 1'b0);
        send_dsp(2, 20, 48, 1, "R4 DSP-A pw1");
        send_dsp(2, 20, 48, 3, "R4/R5 DSP-A pw3");
        finish_case(0, "R4");
        // R7 short word
        start(3, 8, 1'b0);
        send_dsp(3, 8, 20, 2, "R7 DSP-B wl8");
        send_dsp(3, 8, 20, 1, "R7 DSP-B wl8");
        finish_case(0, "R7");
        // R6 pulse low for one bit before next start -> one error
        start(3, 16, 1'b0);
        send_dsp(3, 16, 40, 1, "R6 frame1");
        send_dsp(3, 16, 40, 39, "R6 frame2");
        send_dsp(3, 16, 40, 38, "R6 frame3");
        send_dsp(3, 16, 40, 1, "R6 frame4");
        finish_case(1, "R6");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule